// File: doc/BRIEF.md
# Auxiliary-Power Isolation and Wake Controller

This block sits between a host bus and a network device core that can be powered either from the host bus supply or from a standby auxiliary supply. It runs on an always-on auxiliary clock. When the bus power-good input drops, the controller cuts the core off from the bus. Bus inputs, bus reset and bus clock no longer reach the core, and every bus output enable is withdrawn. The wake line is the one exception: it remains under control and stays driven.

The controller latches an auxiliary-power strap, but only while a reset is in force. That reset is either the alternate power-on reset or a bus reset that arrives while the bus is powered. The latched strap decides a 3-bit auxiliary-current code in the power-management capability field.

Wake requests depend on two things: the current device power state and the direction of a change in link status. A request stays pending on an active-low wake output until it is cleared through the bus or by the alternate reset.

Top module: `auxIsoController`

## Requirements
- R1: While `altRstN` is low, `isolated` is 1, `busOutEn` is all zeros, `pmeN` is 1 and `capAuxField` is 0.
- R2: `isolated` rises on the third clock edge after `busPwrGood` falls. While `isolated` is 1:
  - `coreIn` is all zeros.
  - `busOutEn` is all zeros.
  - `coreBusClk` is 0.
  
  While `isolated` is 0:
  - `coreIn` equals `busIn`.
  - `busOutEn` equals `coreOutEn`.
  - `busOut` always equals `coreOut`.
- R3: After `busPwrGood` rises, `isolated` stays 1 for three clock edges and falls on the fourth. With GLITCH_CYCLES=2, a high pulse on `busPwrGood` lasting one clock period does not end isolation.
- R4: A low `busRstN` drives `coreBusRstN` low two clock edges later when the block is not isolated. While isolated, `coreBusRstN` stays 1 whatever `busRstN` does.
- R5: The strap `strapAux` is latched only in two cases:
  - during the alternate reset and the two clocks after its release;
  - while a bus reset is honoured (not isolated).
  
  `capAuxField` reads AUX_CURRENT (default 5) when the latched strap is 1 and 0 when it is 0. It holds its value when `strapAux` changes outside those windows.
- R6: Power-state codes are 0 (full power, uninitialised) and 1 (full power, active). In these two states a falling edge of `linkValid` sets the wake request whatever `wakeEnable` is. A rising edge does not set it.
- R7: Codes 2, 3 and 4 are the low-power states. In these states a rising edge of `linkValid` sets the wake request when `wakeEnable` is 1. A falling edge does not set it.
- R8: In codes 2 to 4 with `wakeEnable` at 0, no wake request is set. Codes 5 to 7 never set one.
- R9: A set wake request drives `pmeN` low two edges after the `linkValid` change. It stays low until a one-cycle `wakeClr` strobe arrives while not isolated. A `wakeClr` during isolation has no effect.
- R10: The wake request can be set while isolated, and `pmeN` follows it during isolation.
- R11: Asserting `altRstN` clears a pending wake request, so `pmeN` returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| auxClk | input | 1 | Always-on auxiliary clock |
| altRstN | input | 1 | Alternate power-on reset, active low, asynchronous assert |
| busPwrGood | input | 1 | Bus power-good; low requests isolation |
| busRstN | input | 1 | Bus reset, active low |
| busClk | input | 1 | Bus clock |
| strapAux | input | 1 | Auxiliary-power strap (shared pin) |
| busIn | input | IN_W | Bus input signals |
| coreOut | input | OUT_W | Core output data toward the bus |
| coreOutEn | input | OUT_W | Core output enables |
| pwrState | input | 3 | Device power state code |
| wakeEnable | input | 1 | Wake-enable bit |
| linkValid | input | 1 | Link status from the PHY side |
| wakeClr | input | 1 | Write-one-to-clear strobe for the wake request |
| coreIn | output | IN_W | Gated bus inputs to the core |
| busOut | output | OUT_W | Bus output data |
| busOutEn | output | OUT_W | Bus output enables (0 = high impedance) |
| coreBusClk | output | 1 | Gated bus clock to the core |
| coreBusRstN | output | 1 | Honoured bus reset to the core, active low |
| pmeN | output | 1 | Wake output, active low, never tri-stated |
| capAuxField | output | 3 | Auxiliary-current code of the capability field |
| isolated | output | 1 | Isolation state |

## Verification
The bench builds the block with its defaults: 8-bit input and output lanes, a two-clock glitch filter and auxiliary-current code 5. These settings keep every isolation entry and exit edge countable cycle by cycle. They also make a one-period power-good pulse land exactly inside the filter window. With the 3-bit power-state code, the bench can sweep all eight codes against both wake-enable values and both link-edge directions. That gives 32 wake cases, each checked against an expected result computed from R6 to R8.

// File: rtl/aux_iso_pkg.sv
package aux_iso_pkg;

  localparam logic [2:0] PS_D0_UNINIT = 3'd0;
  localparam logic [2:0] PS_D0_ACTIVE = 3'd1;
  localparam logic [2:0] PS_D1        = 3'd2;
  localparam logic [2:0] PS_D2        = 3'd3;
  localparam logic [2:0] PS_D3        = 3'd4;

  typedef struct packed {
    logic isolate;     // bus is cut off
    logic busReset;    // honoured bus reset
    logic sampleStrap; // strap capture window
    logic wakeSet;     // wake event this cycle
    logic wakeClear;   // honoured clear strobe
  } ctrlStrobes_t;

endpackage

// File: rtl/auxSyncChain.sv
module auxSyncChain #(
  parameter int WIDTH = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [STAGES-1:0][WIDTH-1:0] stageQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stageQ[i] <= RESET_VAL;
    end else begin
      stageQ[0] <= asyncIn;
      for (int i = 1; i < STAGES; i++) stageQ[i] <= stageQ[i-1];
    end
  end

  assign syncOut = stageQ[STAGES-1];
endmodule

// File: rtl/auxIsoCtrl.sv
module auxIsoCtrl
  import aux_iso_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int GLITCH_CYCLES = 2
) (
  input  logic         clk,
  input  logic         altRstN,
  input  logic         busPwrGood,
  input  logic         busRstN,
  input  logic         linkValid,
  input  logic [2:0]   pwrState,
  input  logic         wakeEnable,
  input  logic         wakeClr,
  output ctrlStrobes_t strobes
);
  localparam int CNT_W = $clog2(GLITCH_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(GLITCH_CYCLES - 1);

  logic [1:0] busSync;
  logic       releaseDone;
  logic       pwrGoodSync;
  logic       busRstSyncN;

  // bit 1: power good, bit 0: bus reset (both start low = isolated / in reset)
  auxSyncChain #(.WIDTH(2), .STAGES(SYNC_STAGES), .RESET_VAL(2'b00)) busSyncU (
    .clk(clk), .rstN(altRstN), .asyncIn({busPwrGood, busRstN}), .syncOut(busSync)
  );

  // alternate-reset release stretcher
  auxSyncChain #(.WIDTH(1), .STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) relSyncU (
    .clk(clk), .rstN(altRstN), .asyncIn(1'b1), .syncOut(releaseDone)
  );

  assign pwrGoodSync = busSync[1];
  assign busRstSyncN = busSync[0];

  // isolation state with exit filter
  logic             isolatedQ;
  logic [CNT_W-1:0] goodCnt;

  always_ff @(posedge clk or negedge altRstN) begin
    if (!altRstN) begin
      isolatedQ <= 1'b1;
      goodCnt   <= '0;
    end else if (!pwrGoodSync) begin
      isolatedQ <= 1'b1;
      goodCnt   <= '0;
    end else if (isolatedQ) begin
      if (goodCnt == CNT_LAST) begin
        isolatedQ <= 1'b0;
        goodCnt   <= '0;
      end else begin
        goodCnt <= goodCnt + 1'b1;
      end
    end
  end

  // link edge detection
  logic linkQ, linkPrevQ, primedQ;

  always_ff @(posedge clk or negedge altRstN) begin
    if (!altRstN) begin
      linkQ     <= 1'b0;
      linkPrevQ <= 1'b0;
      primedQ   <= 1'b0;
    end else begin
      linkQ     <= linkValid;
      linkPrevQ <= primedQ ? linkQ : linkValid;
      primedQ   <= 1'b1;
    end
  end

  logic linkRise, linkFall, wakeEvent;
  assign linkRise = primedQ & linkQ & ~linkPrevQ;
  assign linkFall = primedQ & ~linkQ & linkPrevQ;

  always_comb begin
    unique case (pwrState)
      PS_D0_UNINIT, PS_D0_ACTIVE: wakeEvent = linkFall;
      PS_D1, PS_D2, PS_D3:        wakeEvent = linkRise & wakeEnable;
      default:                    wakeEvent = 1'b0;
    endcase
  end

  always_comb begin
    strobes.isolate     = isolatedQ;
    strobes.busReset    = ~busRstSyncN & ~isolatedQ;
    strobes.sampleStrap = ~releaseDone | (~busRstSyncN & ~isolatedQ);
    strobes.wakeSet     = wakeEvent;
    strobes.wakeClear   = wakeClr & ~isolatedQ;
  end
endmodule

// File: rtl/auxIsoDatapath.sv
module auxIsoDatapath
  import aux_iso_pkg::*;
#(
  parameter int IN_W = 8,
  parameter int OUT_W = 8,
  parameter logic [2:0] AUX_CURRENT = 3'd5
) (
  input  logic             clk,
  input  logic             altRstN,
  input  ctrlStrobes_t     strobes,
  input  logic             strapAux,
  input  logic             busClk,
  input  logic [IN_W-1:0]  busIn,
  input  logic [OUT_W-1:0] coreOut,
  input  logic [OUT_W-1:0] coreOutEn,
  output logic [IN_W-1:0]  coreIn,
  output logic [OUT_W-1:0] busOut,
  output logic [OUT_W-1:0] busOutEn,
  output logic             coreBusClk,
  output logic             coreBusRstN,
  output logic             pmeN,
  output logic [2:0]       capAuxField
);
  logic strapQ, wakeQ;

  always_ff @(posedge clk or negedge altRstN) begin
    if (!altRstN) strapQ <= 1'b0;
    else if (strobes.sampleStrap) strapQ <= strapAux;
  end

  always_ff @(posedge clk or negedge altRstN) begin
    if (!altRstN) wakeQ <= 1'b0;
    else if (strobes.wakeSet) wakeQ <= 1'b1;
    else if (strobes.wakeClear) wakeQ <= 1'b0;
  end

  genvar gi;
  generate
    for (gi = 0; gi < IN_W; gi++) begin : gInLane
      assign coreIn[gi] = busIn[gi] & ~strobes.isolate;
    end
    for (gi = 0; gi < OUT_W; gi++) begin : gOutLane
      assign busOut[gi]   = coreOut[gi];
      assign busOutEn[gi] = coreOutEn[gi] & ~strobes.isolate;
    end
  endgenerate

  assign coreBusClk  = busClk & ~strobes.isolate;
  assign coreBusRstN = ~strobes.busReset;
  assign pmeN        = ~wakeQ;
  assign capAuxField = strapQ ? AUX_CURRENT : 3'd0;
endmodule

// File: rtl/auxIsoController.sv
module auxIsoController
  import aux_iso_pkg::*;
#(
  parameter int IN_W = 8,
  parameter int OUT_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter int GLITCH_CYCLES = 2,
  parameter logic [2:0] AUX_CURRENT = 3'd5
) (
  input  logic             auxClk,
  input  logic             altRstN,
  input  logic             busPwrGood,
  input  logic             busRstN,
  input  logic             busClk,
  input  logic             strapAux,
  input  logic [IN_W-1:0]  busIn,
  input  logic [OUT_W-1:0] coreOut,
  input  logic [OUT_W-1:0] coreOutEn,
  input  logic [2:0]       pwrState,
  input  logic             wakeEnable,
  input  logic             linkValid,
  input  logic             wakeClr,
  output logic [IN_W-1:0]  coreIn,
  output logic [OUT_W-1:0] busOut,
  output logic [OUT_W-1:0] busOutEn,
  output logic             coreBusClk,
  output logic             coreBusRstN,
  output logic             pmeN,
  output logic [2:0]       capAuxField,
  output logic             isolated
);
  ctrlStrobes_t strobes;

  auxIsoCtrl #(.SYNC_STAGES(SYNC_STAGES), .GLITCH_CYCLES(GLITCH_CYCLES)) ctrlU (
    .clk(auxClk), .altRstN(altRstN), .busPwrGood(busPwrGood), .busRstN(busRstN),
    .linkValid(linkValid), .pwrState(pwrState), .wakeEnable(wakeEnable),
    .wakeClr(wakeClr), .strobes(strobes)
  );

  auxIsoDatapath #(.IN_W(IN_W), .OUT_W(OUT_W), .AUX_CURRENT(AUX_CURRENT)) dpU (
    .clk(auxClk), .altRstN(altRstN), .strobes(strobes), .strapAux(strapAux),
    .busClk(busClk), .busIn(busIn), .coreOut(coreOut), .coreOutEn(coreOutEn),
    .coreIn(coreIn), .busOut(busOut), .busOutEn(busOutEn), .coreBusClk(coreBusClk),
    .coreBusRstN(coreBusRstN), .pmeN(pmeN), .capAuxField(capAuxField)
  );

  assign isolated = strobes.isolate;
endmodule

// File: rtl/auxIsoChecker.sv
module auxIsoChecker #(
  parameter int IN_W = 8,
  parameter int OUT_W = 8
) (
  input logic             auxClk,
  input logic             altRstN,
  input logic             isolated,
  input logic [IN_W-1:0]  coreIn,
  input logic [OUT_W-1:0] busOutEn,
  input logic             coreBusRstN,
  input logic             pmeN,
  input logic             wakeClr,
  input logic [2:0]       pwrState,
  input logic             wakeEnable,
  input logic             sampleStrap,
  input logic [2:0]       capAuxField
);
  // R2
  iso_gate_chk: assert property (@(posedge auxClk) disable iff (!altRstN)
    isolated |-> (busOutEn == '0 && coreIn == '0));

  // R4
  iso_reset_block_chk: assert property (@(posedge auxClk) disable iff (!altRstN)
    isolated |-> coreBusRstN);

  // R9
  wake_hold_chk: assert property (@(posedge auxClk) disable iff (!altRstN)
    (!pmeN && !wakeClr) |=> !pmeN);

  // R8
  no_wake_chk: assert property (@(posedge auxClk) disable iff (!altRstN)
    (pmeN && pwrState >= 3'd2 && !wakeEnable) |=> pmeN);

  // R5
  strap_hold_chk: assert property (@(posedge auxClk) disable iff (!altRstN)
    !sampleStrap |=> $stable(capAuxField));
endmodule

bind auxIsoController auxIsoChecker #(.IN_W(IN_W), .OUT_W(OUT_W)) chkU (
  .auxClk(auxClk), .altRstN(altRstN), .isolated(isolated), .coreIn(coreIn),
  .busOutEn(busOutEn), .coreBusRstN(coreBusRstN), .pmeN(pmeN), .wakeClr(wakeClr),
  .pwrState(pwrState), .wakeEnable(wakeEnable), .sampleStrap(strobes.sampleStrap),
  .capAuxField(capAuxField)
);

// File: tb/auxIsoController_test.sv
module auxIsoController_test;
  localparam int IN_W = 8;
  localparam int OUT_W = 8;
  localparam logic [2:0] AUX_CODE = 3'd5;

  logic auxClk = 1'b0;
  logic altRstN, busPwrGood, busRstN, busClk, strapAux;
  logic [IN_W-1:0] busIn;
  logic [OUT_W-1:0] coreOut, coreOutEn;
  logic [2:0] pwrState;
  logic wakeEnable, linkValid, wakeClr;
  logic [IN_W-1:0] coreIn;
  logic [OUT_W-1:0] busOut, busOutEn;
  logic coreBusClk, coreBusRstN, pmeN, isolated;
  logic [2:0] capAuxField;

  int checks = 0;
  int failures = 0;

  always #4 auxClk = ~auxClk;

  auxIsoController uut (
    .auxClk(auxClk), .altRstN(altRstN), .busPwrGood(busPwrGood), .busRstN(busRstN),
    .busClk(busClk), .strapAux(strapAux), .busIn(busIn), .coreOut(coreOut),
    .coreOutEn(coreOutEn), .pwrState(pwrState), .wakeEnable(wakeEnable),
    .linkValid(linkValid), .wakeClr(wakeClr), .coreIn(coreIn), .busOut(busOut),
    .busOutEn(busOutEn), .coreBusClk(coreBusClk), .coreBusRstN(coreBusRstN),
    .pmeN(pmeN), .capAuxField(capAuxField), .isolated(isolated)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge auxClk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearWake();
    wakeClr = 1'b1; tick(1); wakeClr = 1'b0; tick(1);
  endtask

  function automatic logic expectWake(input int ps, input logic en, input logic rise);
    if (ps <= 1) return !rise;
    if (ps <= 4) return rise && en;
    return 1'b0;
  endfunction

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    altRstN = 0; busPwrGood = 1; busRstN = 1; busClk = 1; strapAux = 0;
    busIn = 8'hA5; coreOut = 8'h3C; coreOutEn = 8'hFF; pwrState = 3'd5;
    wakeEnable = 0; linkValid = 0; wakeClr = 0;
    tick(3);
    // R1 reset state
    check("R1 isolated", isolated, 1);
    check("R1 busOutEn", busOutEn, 0);
    check("R1 pmeN", pmeN, 1);
    check("R1 capAuxField", capAuxField, 0);
    altRstN = 1;
    tick(8);
    // R2 pass-through when powered
    check("R2 not isolated", isolated, 0);
    check("R2 coreIn", coreIn, 8'hA5);
    check("R2 busOutEn", busOutEn, 8'hFF);
    check("R2 busOut", busOut, 8'h3C);
    check("R2 coreBusClk", coreBusClk, 1);

    // R2 entry timing
    busPwrGood = 0;
    tick(2);
    check("R2 entry not yet", isolated, 0);
    tick(1);
    check("R2 entry", isolated, 1);
    check("R2 coreIn gated", coreIn, 0);
    check("R2 busOutEn gated", busOutEn, 0);
    check("R2 coreBusClk gated", coreBusClk, 0);
    check("R2 busOut data", busOut, 8'h3C);

    // R3 single-period glitch does not end isolation
    busPwrGood = 1; tick(1); busPwrGood = 0;
    tick(6);
    check("R3 glitch ignored", isolated, 1);

    // R4 bus reset ignored while isolated; R5 strap not sampled
    strapAux = 1; busRstN = 0;
    tick(4);
    check("R4 reset blocked", coreBusRstN, 1);
    busRstN = 1;
    tick(4);
    check("R5 no strap while isolated", capAuxField, 0);

    // R3 exit timing
    busPwrGood = 1;
    tick(3);
    check("R3 exit not yet", isolated, 1);
    tick(1);
    check("R3 exit", isolated, 0);

    // R4 and R5 honoured bus reset samples strap
    busRstN = 0;
    tick(1);
    check("R4 reset latency", coreBusRstN, 1);
    tick(2);
    check("R4 reset honoured", coreBusRstN, 0);
    busRstN = 1;
    tick(4);
    check("R5 strap high", capAuxField, AUX_CODE);
    strapAux = 0;
    tick(4);
    check("R5 strap held", capAuxField, AUX_CODE);
    busRstN = 0; tick(4); busRstN = 1; tick(4);
    check("R5 strap low", capAuxField, 0);

    // R6 R7 R8 sweep over all power codes, enable values and edge directions
    for (int ps = 0; ps < 8; ps++) begin
      for (int en = 0; en < 2; en++) begin
        for (int rise = 0; rise < 2; rise++) begin
          logic exp;
          pwrState = 3'd5;
          linkValid = (rise == 1) ? 1'b0 : 1'b1;
          tick(3);
          clearWake();
          pwrState = 3'(ps); wakeEnable = en[0];
          tick(1);
          linkValid = ~linkValid;
          tick(1);
          check("R9 latency", pmeN, 1);
          tick(3);
          exp = expectWake(ps, en[0], rise[0]);
          if (ps <= 1) check("R6 full-power wake", pmeN, !exp);
          else if (ps <= 4 && en == 1) check("R7 low-power wake", pmeN, !exp);
          else check("R8 no wake", pmeN, !exp);
          pwrState = 3'd5;
          tick(3);
          check("R9 sticky", pmeN, !exp);
          clearWake();
          check("R9 cleared", pmeN, 1);
        end
      end
    end

    // R10 wake while isolated, R9 clear ignored while isolated
    pwrState = 3'd5; linkValid = 0; tick(3);
    busPwrGood = 0; tick(4);
    pwrState = 3'd4; wakeEnable = 1; tick(1);
    linkValid = 1; tick(3);
    check("R10 isolated", isolated, 1);
    check("R10 pme during isolation", pmeN, 0);
    clearWake();
    check("R9 clear ignored isolated", pmeN, 0);
    busPwrGood = 1; tick(6);
    clearWake();
    check("R9 clear after exit", pmeN, 1);

    // R11 alternate reset clears wake
    pwrState = 3'd1; linkValid = 0; tick(4);
    check("R11 wake set", pmeN, 0);
    altRstN = 0; tick(1);
    check("R11 cleared", pmeN, 1);
    check("R1 isolated again", isolated, 1);
    altRstN = 1; tick(8);
    check("R11 stays clear", pmeN, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule